// File: doc/BRIEF.md
# Gradient-Descent Channel Estimate Updater

This block performs one fixed-point gradient-descent step on a channel estimate matrix. The estimate has `ROWS` rows and `COLS = 2*USERS` columns of signed 8-bit entries. Each new entry is the old entry minus a scaled error term. The error term is the matching entry of the product of the old estimate and a square bit-correlation matrix, less the matching entry of a signal-correlation matrix. Both correlation matrices stay outside the block and are read through simple combinational register-file read ports. The block addresses them and expects the data in the same cycle.

A single multiply-accumulate unit is shared across all the work. For each entry it sums `COLS` products into a 16-bit wrapping accumulator and then subtracts the correlation term. It then applies the step size as an arithmetic right shift and subtracts the result from the old entry, saturating to 8 bits. The old estimate sits in one bank and the new one is written into a second bank. The two banks trade roles when the pass finishes, so the old values stay readable and unchanged for the whole pass. A host loads and reads the estimate through a small read/write port, then pulses `start` and waits for `done`.

Top module: `gd_estimate_updater`

## Requirements
- R1: After a pass, entry (n,j) equals sat8(A[n][j] - (E >>> 8)). E is the 16-bit two's-complement value (sum over m of A[n][m]*Rbb[m][j]) - Rbr[n][j], with all sums wrapping modulo 2^16. A denotes the estimate before the pass.
- R2: For entry (n,j), the bit-correlation port is addressed with row m and column j, for m = 0 to COLS-1 in turn. The signal-correlation port is addressed with row n and column j.
- R3: Reads of the estimate port return the previous estimate for as long as `busy` is high. The new estimate becomes readable from the cycle in which `done` is high.
- R4: A result above +127 is replaced by +127, and a result below -128 is replaced by -128.
- R5: `done` is a one-cycle pulse that goes high exactly ROWS*COLS*(COLS+2) clock cycles after the edge that accepts `start`. `busy` is high from that edge until `done` rises, and `busy` is low while `done` is high.
- R6: After synchronous reset, `busy` and `done` are low and every estimate entry reads 0.
- R7: While `busy` is high, estimate-port writes and `start` are ignored. They do not change the result or the completion time.
- R8: While idle, a write to the estimate port at flat index n*COLS+j stores the value there. A read returns the stored value combinationally in the same cycle.
- R9: The shift rounds toward minus infinity. An error of -1 produces a correction of -1, so the entry grows by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one update pass (accepted when idle) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| rbb_row | output | clog2(COLS) | Bit-correlation read row |
| rbb_col | output | clog2(COLS) | Bit-correlation read column |
| rbb_data | input | 8 | Bit-correlation entry, signed |
| rbr_row | output | clog2(ROWS) | Signal-correlation read row |
| rbr_col | output | clog2(COLS) | Signal-correlation read column |
| rbr_data | input | 16 | Signal-correlation entry, signed |
| est_addr | input | clog2(ROWS*COLS) | Estimate port flat index n*COLS+j |
| est_we | input | 1 | Estimate write enable (idle only) |
| est_wdata | input | 8 | Estimate write value, signed |
| est_rdata | output | 8 | Estimate read value, signed |

## Verification
The assertions take for granted that the correlation ports return data for the address presented in that same cycle. They also assume `start` is sampled only on clock edges, with no multi-cycle meaning to its width. The bench drives both correlation ports combinationally from its own matrices, indexed by the block's address outputs. It changes `start` and the estimate-port inputs only on falling edges. Random matrices use the full signed ranges, so accumulator wrap, negative shifts and saturation all occur. Directed cases pin down the saturation limits and the rounding of the shift.

// File: rtl/gd_pkg.sv
package gd_pkg;

    typedef enum logic [1:0] {
        GD_IDLE = 2'd0,
        GD_MAC  = 2'd1,
        GD_ERR  = 2'd2,
        GD_UPD  = 2'd3
    } gd_state_e;

    typedef struct packed {
        logic acc_clr;
        logic acc_mac;
        logic acc_err;
        logic wr_new;
    } gd_ctrl_t;

    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/gd_sequencer.sv
module gd_sequencer
    import gd_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int RW = idx_bits(ROWS),
    localparam int CW = idx_bits(COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          swap,
    output gd_ctrl_t      ctrl,
    output logic [RW-1:0] row_idx,
    output logic [CW-1:0] col_idx,
    output logic [CW-1:0] term_idx,
    output logic [CW-1:0] dp_col
);
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
    localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

    gd_state_e state;
    logic      last_entry;

    assign busy       = (state != GD_IDLE);
    assign last_entry = (row_idx == ROW_LAST) && (col_idx == COL_LAST);
    assign swap       = (state == GD_UPD) && last_entry;
    assign dp_col     = (state == GD_UPD) ? col_idx : term_idx;

    always_comb begin
        ctrl         = '0;
        ctrl.acc_clr = (state == GD_IDLE) || (state == GD_UPD);
        ctrl.acc_mac = (state == GD_MAC);
        ctrl.acc_err = (state == GD_ERR);
        ctrl.wr_new  = (state == GD_UPD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= GD_IDLE;
            done     <= 1'b0;
            row_idx  <= '0;
            col_idx  <= '0;
            term_idx <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                GD_IDLE: begin
                    if (start) begin
                        row_idx  <= '0;
                        col_idx  <= '0;
                        term_idx <= '0;
                        state    <= GD_MAC;
                    end
                end
                GD_MAC: begin
                    if (term_idx == COL_LAST) begin
                        term_idx <= '0;
                        state    <= GD_ERR;
                    end else begin
                        term_idx <= term_idx + 1'b1;
                    end
                end
                GD_ERR: state <= GD_UPD;
                GD_UPD: begin
                    if (col_idx == COL_LAST) begin
                        col_idx <= '0;
                        if (row_idx == ROW_LAST) begin
                            state <= GD_IDLE;
                            done  <= 1'b1;
                        end else begin
                            row_idx <= row_idx + 1'b1;
                            state   <= GD_MAC;
                        end
                    end else begin
                        col_idx <= col_idx + 1'b1;
                        state   <= GD_MAC;
                    end
                end
                default: state <= GD_IDLE;
            endcase
        end
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_term_range_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (term_idx <= COL_LAST));
    assert_err_single_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl.acc_err |=> ctrl.wr_new);
endmodule

// File: rtl/gd_mac.sv
module gd_mac
    import gd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int ACCW  = 16,
    parameter int SHIFT = 8,
    localparam int EW   = ACCW + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  gd_ctrl_t               ctrl,
    input  logic signed [DW-1:0]   a_op,
    input  logic signed [DW-1:0]   rbb_op,
    input  logic signed [ACCW-1:0] rbr_op,
    output logic signed [DW-1:0]   new_val
);
    logic signed [2*DW-1:0] prod;
    logic signed [ACCW-1:0] prod_x;
    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] corr;
    logic signed [EW-1:0]   diff;
    logic                   in_range;

    assign prod   = a_op * rbb_op;
    assign prod_x = ACCW'(prod);
    assign corr   = acc >>> SHIFT;
    assign diff   = {{(EW-DW){a_op[DW-1]}}, a_op} - {corr[ACCW-1], corr};

    always_comb begin
        in_range = (diff[EW-1:DW-1] == '0) || (diff[EW-1:DW-1] == '1);
        if (in_range)         new_val = diff[DW-1:0];
        else if (diff[EW-1])  new_val = {1'b1, {(DW-1){1'b0}}};
        else                  new_val = {1'b0, {(DW-1){1'b1}}};
    end

    always_ff @(posedge clk) begin
        if (rst)               acc <= '0;
        else if (ctrl.acc_clr) acc <= '0;
        else if (ctrl.acc_mac) acc <= acc + prod_x;
        else if (ctrl.acc_err) acc <= acc - rbr_op;
    end

    assert_sat_sign_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.wr_new && !in_range) |-> (new_val[DW-1] == diff[EW-1]));
    assert_acc_clear_R1: assert property (@(posedge clk) disable iff (rst)
        ctrl.acc_clr |=> (acc == '0));
endmodule

// File: rtl/gd_bank_pair.sv
module gd_bank_pair #(
    parameter int DW  = 8,
    parameter int ENT = 16,
    parameter int IW  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 busy,
    input  logic                 swap,
    input  logic [IW-1:0]        dp_raddr,
    output logic signed [DW-1:0] dp_rdata,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_addr,
    input  logic signed [DW-1:0] wr_data,
    input  logic                 ext_we,
    input  logic [IW-1:0]        ext_addr,
    input  logic signed [DW-1:0] ext_wdata,
    output logic signed [DW-1:0] ext_rdata
);
    logic signed [DW-1:0] mem [2][ENT];
    logic                 sel;

    assign dp_rdata  = mem[sel][dp_raddr];
    assign ext_rdata = mem[sel][ext_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= 1'b0;
            for (int b = 0; b < 2; b++)
                for (int e = 0; e < ENT; e++)
                    mem[b][e] <= '0;
        end else begin
            if (wr_en)  mem[~sel][wr_addr] <= wr_data;
            if (ext_we) mem[sel][ext_addr] <= ext_wdata;
            if (swap)   sel <= ~sel;
        end
    end

    assert_bank_hold_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> $stable(sel));
    assert_bank_swap_R3: assert property (@(posedge clk) disable iff (rst)
        swap |=> (sel != $past(sel)));
endmodule

// File: rtl/gd_estimate_updater.sv
module gd_estimate_updater
    import gd_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int USERS = 2,
    parameter int DW    = 8,
    parameter int ACCW  = 16,
    parameter int SHIFT = 8,
    localparam int COLS = 2 * USERS,
    localparam int ENT  = ROWS * COLS,
    localparam int RW   = idx_bits(ROWS),
    localparam int CW   = idx_bits(COLS),
    localparam int IW   = idx_bits(ENT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    output logic                   busy,
    output logic                   done,
    output logic [CW-1:0]          rbb_row,
    output logic [CW-1:0]          rbb_col,
    input  logic signed [DW-1:0]   rbb_data,
    output logic [RW-1:0]          rbr_row,
    output logic [CW-1:0]          rbr_col,
    input  logic signed [ACCW-1:0] rbr_data,
    input  logic [IW-1:0]          est_addr,
    input  logic                   est_we,
    input  logic signed [DW-1:0]   est_wdata,
    output logic signed [DW-1:0]   est_rdata
);
    gd_ctrl_t             ctrl;
    logic                 swap;
    logic [RW-1:0]        row_idx;
    logic [CW-1:0]        col_idx, term_idx, dp_col;
    logic [IW-1:0]        dp_raddr, wr_addr;
    logic signed [DW-1:0] a_op, new_val;

    gd_sequencer #(.ROWS(ROWS), .COLS(COLS)) u_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .swap(swap), .ctrl(ctrl), .row_idx(row_idx), .col_idx(col_idx),
        .term_idx(term_idx), .dp_col(dp_col)
    );

    assign rbb_row  = term_idx;
    assign rbb_col  = col_idx;
    assign rbr_row  = row_idx;
    assign rbr_col  = col_idx;
    assign dp_raddr = IW'(row_idx) * IW'(COLS) + IW'(dp_col);
    assign wr_addr  = IW'(row_idx) * IW'(COLS) + IW'(col_idx);

    gd_bank_pair #(.DW(DW), .ENT(ENT), .IW(IW)) u_banks (
        .clk(clk), .rst(rst), .busy(busy), .swap(swap),
        .dp_raddr(dp_raddr), .dp_rdata(a_op),
        .wr_en(ctrl.wr_new), .wr_addr(wr_addr), .wr_data(new_val),
        .ext_we(est_we && !busy), .ext_addr(est_addr),
        .ext_wdata(est_wdata), .ext_rdata(est_rdata)
    );

    gd_mac #(.DW(DW), .ACCW(ACCW), .SHIFT(SHIFT)) u_mac (
        .clk(clk), .rst(rst), .ctrl(ctrl), .a_op(a_op),
        .rbb_op(rbb_data), .rbr_op(rbr_data), .new_val(new_val)
    );

    assert_start_to_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !swap) |=> busy);
endmodule

// File: tb/tb_gd_estimate_updater.sv
module tb_gd_estimate_updater;
    localparam int ROWS = 4;
    localparam int USERS = 2;
    localparam int COLS = 2 * USERS;
    localparam int ENT = ROWS * COLS;
    localparam int PASS_CYC = ROWS * COLS * (COLS + 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done;
    logic [1:0] rbb_row, rbb_col, rbr_row, rbr_col;
    logic signed [7:0] rbb_data;
    logic signed [15:0] rbr_data;
    logic [3:0] est_addr = '0;
    logic est_we = 1'b0;
    logic signed [7:0] est_wdata = '0;
    logic signed [7:0] est_rdata;

    logic signed [7:0]  a_m   [ROWS][COLS];
    logic signed [7:0]  rbb_m [COLS][COLS];
    logic signed [15:0] rbr_m [ROWS][COLS];
    logic signed [7:0]  exp_m [ROWS][COLS];

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    always_comb rbb_data = rbb_m[rbb_row][rbb_col];
    always_comb rbr_data = rbr_m[rbr_row][rbr_col];

    gd_estimate_updater dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .rbb_row(rbb_row), .rbb_col(rbb_col), .rbb_data(rbb_data),
        .rbr_row(rbr_row), .rbr_col(rbr_col), .rbr_data(rbr_data),
        .est_addr(est_addr), .est_we(est_we), .est_wdata(est_wdata),
        .est_rdata(est_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic signed [7:0] ref_entry(input int n, input int j);
        logic [15:0] acc = '0;
        logic signed [15:0] e;
        int corr, diff;
        for (int m = 0; m < COLS; m++)
            acc = acc + 16'(int'(a_m[n][m]) * int'(rbb_m[m][j]));
        acc = acc - rbr_m[n][j];
        e = signed'(acc);
        corr = int'(e) >>> 8;
        diff = int'(a_m[n][j]) - corr;
        if (diff > 127) diff = 127;
        if (diff < -128) diff = -128;
        return 8'(diff);
    endfunction

    task automatic write_est(input int idx, input logic signed [7:0] v);
        @(negedge clk);
        est_addr = 4'(idx); est_wdata = v; est_we = 1'b1;
        @(negedge clk);
        est_we = 1'b0;
    endtask

    task automatic load_model;
        for (int n = 0; n < ROWS; n++)
            for (int j = 0; j < COLS; j++)
                write_est(n * COLS + j, a_m[n][j]);
    endtask

    task automatic run_pass(input bit poke_busy);
        int cnt;
        for (int n = 0; n < ROWS; n++)
            for (int j = 0; j < COLS; j++)
                exp_m[n][j] = ref_entry(n, j);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        check(busy === 1'b1, "R5 busy after start", int'(busy), 1);
        while (cnt < PASS_CYC + 20) begin
            @(negedge clk);
            cnt++;
            if (cnt == 3) begin
                est_addr = 4'(ENT - 1);
                #1;
                check(est_rdata === a_m[ROWS-1][COLS-1], "R3 old estimate held",
                      int'(est_rdata), int'(a_m[ROWS-1][COLS-1]));
            end
            if (poke_busy && cnt == 5) begin
                est_addr = 4'd0; est_wdata = 8'sd55; est_we = 1'b1; start = 1'b1;
            end
            if (poke_busy && cnt == 6) begin
                est_we = 1'b0; start = 1'b0;
            end
            if (done) break;
            if (cnt < PASS_CYC && !busy)
                check(1'b0, "R5 busy dropped early", cnt, PASS_CYC);
        end
        check(cnt == PASS_CYC, "R5 done timing", cnt, PASS_CYC);
        check(busy === 1'b0, "R5 busy low with done", int'(busy), 0);
        for (int n = 0; n < ROWS; n++)
            for (int j = 0; j < COLS; j++) begin
                est_addr = 4'(n * COLS + j);
                #1;
                check(est_rdata === exp_m[n][j], "R1 R2 entry value",
                      int'(est_rdata), int'(exp_m[n][j]));
                a_m[n][j] = exp_m[n][j];
            end
        @(negedge clk);
        check(done === 1'b0, "R5 done one cycle", int'(done), 0);
        check(busy === 1'b0, "R7 no restart from busy start", int'(busy), 0);
    endtask

    task automatic fill(input bit full);
        for (int n = 0; n < ROWS; n++)
            for (int j = 0; j < COLS; j++) begin
                a_m[n][j]   = full ? 8'($urandom) : 8'($urandom_range(0, 40) - 20);
                rbr_m[n][j] = 16'($urandom);
            end
        for (int m = 0; m < COLS; m++)
            for (int j = 0; j < COLS; j++)
                rbb_m[m][j] = full ? 8'($urandom) : 8'($urandom_range(0, 40) - 20);
    endtask

    task automatic fill_const(input logic signed [7:0] av, input logic signed [15:0] rv);
        for (int n = 0; n < ROWS; n++)
            for (int j = 0; j < COLS; j++) begin
                a_m[n][j] = av; rbr_m[n][j] = rv;
            end
        for (int m = 0; m < COLS; m++)
            for (int j = 0; j < COLS; j++)
                rbb_m[m][j] = '0;
    endtask

    initial begin
        process p;
        p = process::self();
        p.srandom(32'd1234);
        fill_const(8'sd0, 16'sd0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0, "R6 busy after reset", int'(busy), 0);
        check(done === 1'b0, "R6 done after reset", int'(done), 0);
        for (int i = 0; i < ENT; i++) begin
            est_addr = 4'(i);
            #1;
            check(est_rdata === 8'sd0, "R6 entry zero", int'(est_rdata), 0);
        end

        // R8: idle write then read back
        fill(1'b1);
        load_model();
        for (int i = 0; i < ENT; i++) begin
            est_addr = 4'(i);
            #1;
            check(est_rdata === a_m[i / COLS][i % COLS], "R8 readback",
                  int'(est_rdata), int'(a_m[i / COLS][i % COLS]));
        end

        // R1/R2 random passes, small and full ranges
        run_pass(1'b0);
        for (int k = 0; k < 3; k++) begin
            fill(1'b0); load_model(); run_pass(1'b0);
        end
        for (int k = 0; k < 3; k++) begin
            fill(1'b1); load_model(); run_pass(1'b0);
        end
        // back-to-back iteration on the updated estimate
        run_pass(1'b0);

        // R4 positive saturation: 100 + 127 -> 127
        fill_const(8'sd100, 16'sh7F00); load_model(); run_pass(1'b0);
        check(a_m[0][0] == 8'sd127, "R4 clip high", int'(a_m[0][0]), 127);
        // R4 negative saturation: -100 - 127 -> -128
        fill_const(-8'sd100, -16'sh7F00); load_model(); run_pass(1'b0);
        check(a_m[1][2] == -8'sd128, "R4 clip low", int'(a_m[1][2]), -128);

        // R9 floor rounding: error -1 gives +1
        fill_const(8'sd0, 16'sd1); load_model(); run_pass(1'b0);
        check(a_m[2][1] == 8'sd1, "R9 floor shift", int'(a_m[2][1]), 1);

        // R7 write and start while busy are ignored
        fill(1'b1); load_model(); run_pass(1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(150000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule